// File: doc/BRIEF.md
# Full-Map Directory Home Controller

This block is the directory engine of one home node in a write-invalidate coherence scheme. For a small set of memory lines it keeps an exact record of which caches hold each line and whether one of them holds it modified. Caches send it read misses, write misses, upgrade requests and replacement notices. For each one it updates the line's record and emits the messages the protocol needs: a reply to the requester, one invalidation to each recorded sharer, a fetch-back request to a remote modified owner, and a strobe that tells the memory to take a written-back line.

Transactions are not atomic. A write to a shared line stays open until every invalidation it sent has been acknowledged. A read or write to a line held modified by a remote cache stays open until that owner has returned the line. While a transaction is open the controller refuses new requests with a nack, and the requester retries later. When the modified owner is the cache attached to the home node itself, the line is recovered locally in the same step, with no fetch message.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every line is uncached and clean, `busy` is low and no output message is valid.
- R2: A read (op 0) of a clean or uncached line replies with data in the cycle after the request and adds the requester to the line's sharers, leaving the line clean.
- R3: A read of a line modified at the home node's own cache (HOME_ID) asserts `wb_valid` and the data reply together in the cycle after the request, sends no fetch, and leaves the line clean with both the old owner and the requester as sharers.
- R4: A read of a line modified in a remote cache emits one fetch to that owner in the cycle after the request, never to HOME_ID. In the cycle after `fetch_rsp_valid` it asserts `wb_valid` and the data reply, and the line becomes clean with owner and requester as sharers.
- R5: A write (op 1) to a clean line with other sharers sends one invalidation per cycle, lowest cache index first, to every sharer except the requester. The reply comes only in the cycle after the acknowledgement count for those invalidations reaches zero. The line then becomes modified with the requester as its only holder.
- R6: A write to a line with no sharer other than the requester replies with data in the cycle after the request and sends no invalidation.
- R7: A write to a modified line recovers it from the owner (locally in one step if the owner is HOME_ID, otherwise by a fetch round trip, both with a `wb_valid` strobe). The line stays modified with the requester as its single holder.
- R8: An upgrade (op 2) from a cache that holds a clean copy behaves as in R5 or R6 but replies with `reply_data` low. An upgrade from any other cache, or to a modified line, is handled as a write with `reply_data` high.
- R9: A replacement (op 3) with `req_dirty` high asserts `wb_valid` in the next cycle and clears the line to uncached. With `req_dirty` low it removes only that cache from the sharers. A replacement never gets a reply.
- R10: A request that arrives while `busy` is high is answered with `nack_valid` and its `nack_cache` in the next cycle and changes no line state. A request accepted while idle is never nacked.
- R11: Acknowledgements arriving while no invalidation is outstanding are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 read, 1 write, 2 upgrade, 3 replace |
| req_cache | input | CW | Requesting cache index |
| req_line | input | LW | Line index |
| req_dirty | input | 1 | Replacement carries modified data |
| ack_valid | input | 1 | One invalidation acknowledgement |
| fetch_rsp_valid | input | 1 | Remote owner returned the line |
| busy | output | 1 | A transaction is open |
| nack_valid | output | 1 | Request refused |
| nack_cache | output | CW | Cache being refused |
| reply_valid | output | 1 | Reply to requester |
| reply_cache | output | CW | Reply destination |
| reply_line | output | LW | Line of the reply |
| reply_data | output | 1 | Reply carries line data |
| inv_valid | output | 1 | Invalidation message |
| inv_cache | output | CW | Invalidation destination |
| inv_line | output | LW | Line being invalidated |
| fetch_valid | output | 1 | Fetch-back request |
| fetch_cache | output | CW | Modified owner asked for the line |
| fetch_line | output | LW | Line being fetched |
| wb_valid | output | 1 | Memory write-back strobe |
| wb_line | output | LW | Line written back |

## Verification
The hardest condition to reach is a refusal that lands in the window where the invalidations have all gone out but acknowledgements are still missing. A further case is a refusal on the very edge at which an open transaction completes. The bench returns each acknowledgement three cycles after its invalidation and each fetch response four cycles after its fetch. It then fires requests back to back behind a write to a line with several sharers, so they land inside that window. A behavioural reference model of the directory is advanced on every clock and compared with every output, so state errors show up in the messages of later transactions.

// File: rtl/dir_pkg.sv
package dir_pkg;

    typedef enum logic [1:0] {
        OP_READ    = 2'd0,
        OP_WRITE   = 2'd1,
        OP_UPGRADE = 2'd2,
        OP_REPLACE = 2'd3
    } dir_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_INVAL = 2'd1,
        ST_FETCH = 2'd2
    } dir_st_e;

    // index of the lowest set bit, 0 when none
    function automatic int unsigned first_set(input logic [31:0] v);
        int unsigned r;
        r = 0;
        for (int i = 31; i >= 0; i--) begin
            if (v[i]) r = i;
        end
        return r;
    endfunction

    function automatic int unsigned count_set(input logic [31:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < 32; i++) begin
            n += v[i];
        end
        return n;
    endfunction

endpackage

// File: rtl/dir_entry_ram.sv
module dir_entry_ram #(
    parameter int NCACHE = 4,
    parameter int NLINE  = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [$clog2(NLINE)-1:0]   wr_line,
    input  logic [NCACHE:0]            wr_data,
    input  logic [$clog2(NLINE)-1:0]   rd_line,
    output logic [NCACHE:0]            rd_data
);
    localparam int EW = NCACHE + 1;

    logic [EW-1:0] entry_q [NLINE];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NLINE; i++) entry_q[i] <= '0;
        end else if (wr_en) begin
            entry_q[wr_line] <= wr_data;
        end
    end

    assign rd_data = entry_q[rd_line];

    AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[0]) |-> ($countones(wr_data[EW-1:1]) == 1)); // R7

endmodule

// File: rtl/dir_inv_tracker.sv
module dir_inv_tracker
    import dir_pkg::*;
#(
    parameter int NCACHE = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        load,
    input  logic [NCACHE-1:0]           load_mask,
    input  logic                        ack_valid,
    output logic                        inv_valid,
    output logic [$clog2(NCACHE)-1:0]   inv_idx,
    output logic                        done
);
    localparam int CW  = $clog2(NCACHE);
    localparam int CNW = $clog2(NCACHE + 1);

    logic [NCACHE-1:0] mask_q;
    logic [CNW-1:0]    owed_q;
    logic [CW-1:0]     pick;
    logic [NCACHE-1:0] pick_bit;

    assign pick     = CW'(first_set(32'(mask_q)));
    assign pick_bit = {{(NCACHE-1){1'b0}}, 1'b1} << pick;
    assign done     = (mask_q == '0) && (owed_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q    <= '0;
            owed_q    <= '0;
            inv_valid <= 1'b0;
            inv_idx   <= '0;
        end else begin
            inv_valid <= 1'b0;
            if (load) begin
                mask_q <= load_mask;
                owed_q <= CNW'(count_set(32'(load_mask)));
            end else begin
                if (mask_q != '0) begin
                    inv_valid <= 1'b1;
                    inv_idx   <= pick;
                    mask_q    <= mask_q & ~pick_bit;
                end
                if (ack_valid && owed_q != '0) owed_q <= owed_q - 1'b1;
            end
        end
    end

    AST_INV_HAS_ACK_DUE: assert property (@(posedge clk) disable iff (rst)
        inv_valid |-> (owed_q != '0)); // R5

    AST_IDLE_ACK_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (!load && ack_valid && owed_q == '0) |=> (owed_q == '0)); // R11

endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
    import dir_pkg::*;
#(
    parameter int NCACHE  = 4,
    parameter int NLINE   = 4,
    parameter int HOME_ID = 0
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    input  logic [1:0]                  req_op,
    input  logic [$clog2(NCACHE)-1:0]   req_cache,
    input  logic [$clog2(NLINE)-1:0]    req_line,
    input  logic                        req_dirty,
    input  logic                        ack_valid,
    input  logic                        fetch_rsp_valid,
    output logic                        busy,
    output logic                        nack_valid,
    output logic [$clog2(NCACHE)-1:0]   nack_cache,
    output logic                        reply_valid,
    output logic [$clog2(NCACHE)-1:0]   reply_cache,
    output logic [$clog2(NLINE)-1:0]    reply_line,
    output logic                        reply_data,
    output logic                        inv_valid,
    output logic [$clog2(NCACHE)-1:0]   inv_cache,
    output logic [$clog2(NLINE)-1:0]    inv_line,
    output logic                        fetch_valid,
    output logic [$clog2(NCACHE)-1:0]   fetch_cache,
    output logic [$clog2(NLINE)-1:0]    fetch_line,
    output logic                        wb_valid,
    output logic [$clog2(NLINE)-1:0]    wb_line
);
    localparam int CW = $clog2(NCACHE);
    localparam int LW = $clog2(NLINE);
    localparam int EW = NCACHE + 1;
    localparam logic [CW-1:0] HOME = CW'(HOME_ID);

    dir_st_e         state_q, state_n;
    dir_op_e         t_op_q;
    logic [CW-1:0]   t_cache_q;
    logic [LW-1:0]   t_line_q;
    logic            t_data_q;

    // directory read side
    logic [LW-1:0]     rd_line;
    logic [EW-1:0]     rd_entry;
    logic              cur_dirty;
    logic [NCACHE-1:0] cur_pres;
    logic [CW-1:0]     owner;
    logic [NCACHE-1:0] req_bit, txn_bit, others;

    // write side and actions
    logic              wr_en;
    logic [EW-1:0]     wr_data;
    logic              go_reply, go_wb, go_fetch, accept, data_flag;
    logic              trk_load, trk_done, trk_inv;
    logic [NCACHE-1:0] trk_mask;
    logic [CW-1:0]     trk_idx;
    dir_op_e           op_in;

    assign op_in     = dir_op_e'(req_op);
    assign rd_line   = (state_q == ST_IDLE) ? req_line : t_line_q;
    assign cur_dirty = rd_entry[0];
    assign cur_pres  = rd_entry[EW-1:1];
    assign owner     = CW'(first_set(32'(cur_pres)));
    assign req_bit   = {{(NCACHE-1){1'b0}}, 1'b1} << req_cache;
    assign txn_bit   = {{(NCACHE-1){1'b0}}, 1'b1} << t_cache_q;
    assign others    = cur_pres & ~req_bit;
    assign accept    = (state_q == ST_IDLE) && req_valid;

    dir_entry_ram #(.NCACHE(NCACHE), .NLINE(NLINE)) u_ram (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_line (rd_line),
        .wr_data (wr_data),
        .rd_line (rd_line),
        .rd_data (rd_entry)
    );

    dir_inv_tracker #(.NCACHE(NCACHE)) u_trk (
        .clk       (clk),
        .rst       (rst),
        .load      (trk_load),
        .load_mask (trk_mask),
        .ack_valid (ack_valid),
        .inv_valid (trk_inv),
        .inv_idx   (trk_idx),
        .done      (trk_done)
    );

    always_comb begin
        state_n   = state_q;
        wr_en     = 1'b0;
        wr_data   = rd_entry;
        go_reply  = 1'b0;
        go_wb     = 1'b0;
        go_fetch  = 1'b0;
        trk_load  = 1'b0;
        trk_mask  = '0;
        data_flag = 1'b1;
        unique case (state_q)
            ST_IDLE: if (req_valid) begin
                unique case (op_in)
                    OP_READ: begin
                        if (cur_dirty && owner != HOME) begin
                            state_n  = ST_FETCH;
                            go_fetch = 1'b1;
                        end else begin
                            go_wb    = cur_dirty;
                            go_reply = 1'b1;
                            wr_en    = 1'b1;
                            wr_data  = {cur_pres | req_bit, 1'b0};
                        end
                    end
                    OP_WRITE, OP_UPGRADE: begin
                        data_flag = !(op_in == OP_UPGRADE && !cur_dirty
                                      && (cur_pres & req_bit) != '0);
                        if (cur_dirty && owner != HOME) begin
                            state_n  = ST_FETCH;
                            go_fetch = 1'b1;
                        end else if (cur_dirty || others == '0) begin
                            go_wb    = cur_dirty;
                            go_reply = 1'b1;
                            wr_en    = 1'b1;
                            wr_data  = {req_bit, 1'b1};
                        end else begin
                            state_n  = ST_INVAL;
                            trk_load = 1'b1;
                            trk_mask = others;
                        end
                    end
                    OP_REPLACE: begin
                        wr_en = 1'b1;
                        if (req_dirty) begin
                            go_wb   = 1'b1;
                            wr_data = '0;
                        end else begin
                            wr_data = {others, cur_dirty};
                        end
                    end
                    default: ;
                endcase
            end
            ST_INVAL: if (trk_done) begin
                state_n   = ST_IDLE;
                go_reply  = 1'b1;
                data_flag = t_data_q;
                wr_en     = 1'b1;
                wr_data   = {txn_bit, 1'b1};
            end
            ST_FETCH: if (fetch_rsp_valid) begin
                state_n   = ST_IDLE;
                go_reply  = 1'b1;
                go_wb     = 1'b1;
                data_flag = t_data_q;
                wr_en     = 1'b1;
                wr_data   = (t_op_q == OP_READ) ? {cur_pres | txn_bit, 1'b0}
                                                : {txn_bit, 1'b1};
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            t_op_q      <= OP_READ;
            t_cache_q   <= '0;
            t_line_q    <= '0;
            t_data_q    <= 1'b0;
            nack_valid  <= 1'b0;
            nack_cache  <= '0;
            reply_valid <= 1'b0;
            reply_cache <= '0;
            reply_line  <= '0;
            reply_data  <= 1'b0;
            fetch_valid <= 1'b0;
            fetch_cache <= '0;
            fetch_line  <= '0;
            wb_valid    <= 1'b0;
            wb_line     <= '0;
        end else begin
            state_q     <= state_n;
            nack_valid  <= req_valid && (state_q != ST_IDLE);
            reply_valid <= go_reply;
            fetch_valid <= go_fetch;
            wb_valid    <= go_wb;
            if (req_valid && state_q != ST_IDLE) nack_cache <= req_cache;
            if (accept) begin
                t_op_q    <= op_in;
                t_cache_q <= req_cache;
                t_line_q  <= req_line;
                t_data_q  <= data_flag;
            end
            if (go_reply) begin
                reply_cache <= accept ? req_cache : t_cache_q;
                reply_line  <= rd_line;
                reply_data  <= data_flag;
            end
            if (go_fetch) begin
                fetch_cache <= owner;
                fetch_line  <= req_line;
            end
            if (go_wb) wb_line <= rd_line;
        end
    end

    assign busy      = (state_q != ST_IDLE);
    assign inv_valid = trk_inv;
    assign inv_cache = trk_idx;
    assign inv_line  = t_line_q;

    AST_NACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && busy) |=> nack_valid); // R10
    AST_NO_NACK_IDLE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> !nack_valid); // R10
    AST_FETCH_REMOTE_ONLY: assert property (@(posedge clk) disable iff (rst)
        fetch_valid |-> (fetch_cache != HOME)); // R4
    AST_FETCH_REPLY_APART: assert property (@(posedge clk) disable iff (rst)
        $onehot0({reply_valid, fetch_valid})); // R4
    AST_INV_SKIPS_REQUESTER: assert property (@(posedge clk) disable iff (rst)
        inv_valid |-> (inv_cache != t_cache_q)); // R5
    AST_WB_CLOSES_TXN: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> !busy); // R3

endmodule

// File: tb/dir_home_ctrl_bench.sv
module dir_home_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 4;
    localparam int NL = 4;
    localparam int HOME = 0;
    localparam int CW = $clog2(NC);
    localparam int LW = $clog2(NL);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [1:0] req_op = '0;
    logic [CW-1:0] req_cache = '0;
    logic [LW-1:0] req_line = '0;
    logic req_dirty = 1'b0;
    logic ack_valid = 1'b0;
    logic fetch_rsp_valid = 1'b0;
    logic busy, nack_valid, reply_valid, reply_data, inv_valid, fetch_valid, wb_valid;
    logic [CW-1:0] nack_cache, reply_cache, inv_cache, fetch_cache;
    logic [LW-1:0] reply_line, inv_line, fetch_line, wb_line;

    always #(CLK_PERIOD/2) clk = ~clk;

    dir_home_ctrl #(.NCACHE(NC), .NLINE(NL), .HOME_ID(HOME)) u_dir_home_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_cache(req_cache), .req_line(req_line), .req_dirty(req_dirty),
        .ack_valid(ack_valid), .fetch_rsp_valid(fetch_rsp_valid), .busy(busy),
        .nack_valid(nack_valid), .nack_cache(nack_cache), .reply_valid(reply_valid),
        .reply_cache(reply_cache), .reply_line(reply_line), .reply_data(reply_data),
        .inv_valid(inv_valid), .inv_cache(inv_cache), .inv_line(inv_line),
        .fetch_valid(fetch_valid), .fetch_cache(fetch_cache), .fetch_line(fetch_line),
        .wb_valid(wb_valid), .wb_line(wb_line)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done_flag = 0;
    string cur_req = "R1";

    // ---------------- reference model ----------------
    int mst;                 // 0 idle, 1 invalidating, 2 fetching
    bit mdirty [NL];
    int mholders [NL][$];    // cache indices holding the line
    int mpend[$];            // invalidations still to send
    int mowed, tc, tl, top_;
    bit tdata;
    bit e_busy, e_nack, e_rep, e_repd, e_inv, e_fet, e_wb;
    int e_nackc, e_repc, e_repl, e_invc, e_invl, e_fetc, e_fetl, e_wbl;

    function automatic bit holds(int l, int c);
        foreach (mholders[l][i]) if (mholders[l][i] == c) return 1;
        return 0;
    endfunction

    function automatic int lowest_holder(int l);
        int best = NC;
        foreach (mholders[l][i]) if (mholders[l][i] < best) best = mholders[l][i];
        return best;
    endfunction

    task automatic add_holder(int l, int c);
        if (!holds(l, c)) mholders[l].push_back(c);
    endtask

    task automatic drop_holder(int l, int c);
        for (int i = mholders[l].size() - 1; i >= 0; i--)
            if (mholders[l][i] == c) mholders[l].delete(i);
    endtask

    task automatic reply_now(int c, int l, bit d);
        e_rep = 1; e_repc = c; e_repl = l; e_repd = d;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            mst = 0; mowed = 0; mpend.delete();
            for (int l = 0; l < NL; l++) begin mdirty[l] = 0; mholders[l].delete(); end
            e_nack = 0; e_rep = 0; e_inv = 0; e_fet = 0; e_wb = 0;
        end else begin
            bit fin;
            int op, c, l, k;
            e_nack = 0; e_rep = 0; e_inv = 0; e_fet = 0; e_wb = 0;
            op = int'(req_op); c = int'(req_cache); l = int'(req_line);
            if (req_valid && mst != 0) begin e_nack = 1; e_nackc = c; end
            if (mst == 0 && req_valid) begin
                tc = c; tl = l; top_ = op;
                k = lowest_holder(l);
                if (op == 0) begin
                    tdata = 1;
                    if (mdirty[l] && k != HOME) begin
                        mst = 2; e_fet = 1; e_fetc = k; e_fetl = l;
                    end else begin
                        if (mdirty[l]) begin e_wb = 1; e_wbl = l; end
                        mdirty[l] = 0; add_holder(l, c); reply_now(c, l, 1);
                    end
                end else if (op == 1 || op == 2) begin
                    tdata = !(op == 2 && !mdirty[l] && holds(l, c));
                    if (mdirty[l] && k != HOME) begin
                        mst = 2; e_fet = 1; e_fetc = k; e_fetl = l;
                    end else begin
                        mpend.delete();
                        for (int j = 0; j < NC; j++)
                            if (j != c && holds(l, j)) mpend.push_back(j);
                        if (mdirty[l] || mpend.size() == 0) begin
                            if (mdirty[l]) begin e_wb = 1; e_wbl = l; end
                            mdirty[l] = 1; mholders[l].delete(); mholders[l].push_back(c);
                            reply_now(c, l, tdata);
                        end else begin
                            mst = 1; mowed = mpend.size();
                        end
                    end
                end else begin
                    if (req_dirty) begin
                        e_wb = 1; e_wbl = l; mdirty[l] = 0; mholders[l].delete();
                    end else drop_holder(l, c);
                end
            end else if (mst == 1) begin
                fin = (mpend.size() == 0) && (mowed == 0);
                if (mpend.size() != 0) begin
                    e_inv = 1; e_invc = mpend.pop_front(); e_invl = tl;
                end
                if (ack_valid && mowed > 0) mowed--;
                if (fin) begin
                    mst = 0; mdirty[tl] = 1; mholders[tl].delete(); mholders[tl].push_back(tc);
                    reply_now(tc, tl, tdata);
                end
            end else if (mst == 2) begin
                if (fetch_rsp_valid) begin
                    mst = 0; e_wb = 1; e_wbl = tl; reply_now(tc, tl, tdata);
                    if (top_ == 0) begin mdirty[tl] = 0; add_holder(tl, tc); end
                    else begin mdirty[tl] = 1; mholders[tl].delete(); mholders[tl].push_back(tc); end
                end
            end
            e_busy = (mst != 0);
        end
    end

    // ---------------- comparison ----------------
    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", cur_req, what, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        if (rst) e_busy = 0;
        else if (!done_flag) begin
            chk("busy", int'(busy), int'(e_busy));
            chk("nack_valid", int'(nack_valid), int'(e_nack));
            if (e_nack) chk("nack_cache", int'(nack_cache), e_nackc);
            chk("reply_valid", int'(reply_valid), int'(e_rep));
            if (e_rep) begin
                chk("reply_cache", int'(reply_cache), e_repc);
                chk("reply_line", int'(reply_line), e_repl);
                chk("reply_data", int'(reply_data), int'(e_repd));
            end
            chk("inv_valid", int'(inv_valid), int'(e_inv));
            if (e_inv) begin
                chk("inv_cache", int'(inv_cache), e_invc);
                chk("inv_line", int'(inv_line), e_invl);
            end
            chk("fetch_valid", int'(fetch_valid), int'(e_fet));
            if (e_fet) begin
                chk("fetch_cache", int'(fetch_cache), e_fetc);
                chk("fetch_line", int'(fetch_line), e_fetl);
            end
            chk("wb_valid", int'(wb_valid), int'(e_wb));
            if (e_wb) chk("wb_line", int'(wb_line), e_wbl);
        end
    end

    // ---------------- remote cache responders ----------------
    logic [2:0] ack_sr = '0;
    logic [3:0] fet_sr = '0;
    bit force_ack = 0;
    always @(negedge clk) begin
        ack_sr <= {ack_sr[1:0], inv_valid};
        fet_sr <= {fet_sr[2:0], fetch_valid};
        ack_valid <= ack_sr[2] | force_ack;
        fetch_rsp_valid <= fet_sr[3];
    end

    // ---------------- stimulus ----------------
    task automatic send(int op, int c, int l, bit d);
        @(negedge clk);
        req_valid <= 1'b1; req_op <= 2'(op); req_cache <= CW'(c);
        req_line <= LW'(l); req_dirty <= d;
        @(negedge clk);
        req_valid <= 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (5) @(negedge clk);
    endtask

    task automatic req(int op, int c, int l, bit d);
        send(op, c, l, d);
        settle();
    endtask

    task automatic finish_run();
        done_flag = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done_flag) begin
            errors++;
            $display("FAIL watchdog %s actual=%0d expected=idle", cur_req, cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst <= 1'b0;
        cur_req = "R1"; repeat (3) @(negedge clk);
        cur_req = "R2"; req(0, 1, 0, 0); req(0, 2, 0, 0); req(0, 3, 0, 0);
        cur_req = "R5"; req(1, 1, 0, 0);                 // invalidate 2,3
        cur_req = "R4"; req(0, 2, 0, 0);                 // remote owner 1
        cur_req = "R10";
        send(1, 3, 0, 0);                                // invalidate 1,2
        send(0, 0, 1, 0); send(1, 1, 0, 0);
        settle();
        cur_req = "R6"; req(1, 0, 1, 0);                 // uncached write
        cur_req = "R3"; req(0, 2, 1, 0);                 // home owner read
        cur_req = "R5"; req(1, 3, 1, 0);                 // invalidate 0,2
        cur_req = "R7"; req(1, 2, 1, 0);                 // remote owner write
        req(1, 0, 2, 0); req(1, 1, 2, 0);                // home owner write
        cur_req = "R8"; req(0, 1, 3, 0); req(0, 2, 3, 0);
        req(2, 1, 3, 0);                                 // upgrade, no data
        req(2, 3, 3, 0);                                 // upgrade on dirty line
        req(0, 0, 2, 0); req(2, 2, 2, 0);                // non-holder upgrade
        cur_req = "R9"; req(3, 3, 3, 1);                 // dirty replacement
        req(0, 2, 3, 0); req(0, 0, 3, 0); req(3, 2, 3, 0);
        req(1, 1, 3, 0);                                 // only cache 0 invalidated
        cur_req = "R11";
        @(negedge clk); force_ack = 1; @(negedge clk); force_ack = 0;
        repeat (3) @(negedge clk);
        req(0, 3, 3, 0); req(1, 2, 3, 0);                // must wait for real acks
        cur_req = "R10";
        send(2, 3, 3, 0); send(0, 1, 3, 0); send(3, 2, 3, 1);
        settle();
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule